// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a memory-mapped timer with `NCH` independent channels behind a plain register bus. Each channel holds a 64-bit interval and a 64-bit down-counter. Both are split into low and high 32-bit words. On every prescaled tick the counter steps down by one. When a step finds the counter already at zero, the channel records an event. A periodic channel then reloads its interval and keeps running. A one-shot channel drops its own enable and stops.

Counting is paced by a base `tick` strobe, which is one cycle wide and qualified by `clk`. Each channel divides that strobe by a power of two of its own choosing. A shared enable register and a shared pending register turn events into the single `irq` line. Pending bits are cleared by writing ones to them.

A write takes effect on the rising edge of `clk` where `bus_wr` is high. A read is combinational from `bus_addr` to `bus_rdata`. There is no handshake, and every access completes in one cycle.

Top module: `cdtimer`

## Requirements
- R1: After reset, every mapped register reads zero and `irq` is low.
- R2: Register map. Offset 0x00 holds the interrupt enables, one bit per channel at the channel index; bits at or above `NCH` read zero. Channel n has its control word at 0x20*n+0x10 and its interval low and high words at +0x14 and +0x18. Control bit 0 is enable, bit 1 is reload, bits 6:4 are the prescale code and bit 7 selects one-shot. Control bits 3:2 and 31:8 read zero.
- R3: The count words at 0x20*n+0x1C (low) and 0x20*n+0x20 (high) are read-only. Writes to them have no effect. Any other offset, any misaligned offset and any channel index at or above `NCH` reads zero, and writes to such offsets change nothing.
- R4: A set reload bit copies the 64-bit interval into the counter on the channel's next prescaled tick, and then reads back as zero.
- R5: While enabled, the counter drops by one on each prescaled tick, with the borrow carried from the low word into the high word.
- R6: Prescale code p gives one prescaled tick every 2^p base ticks. A control write restarts the phase, so the first prescaled tick comes on the 2^p-th base tick after the write.
- R7: A prescaled tick that finds an active counter at zero sets the channel's pending bit (offset 0x04, bit n) whether or not its interrupt is enabled. In periodic mode the same tick reloads the interval, so an interval of N gives one event every N+1 prescaled ticks.
- R8: In one-shot mode the event clears the enable bit, and the counter then stays at zero.
- R9: Writing 1 to a pending bit clears it. An event in the same cycle wins, and the bit stays set.
- R10: `irq` is high exactly when some channel has both its pending bit and its enable bit set.
- R11: After a control write clears the enable bit, the channel stays active for `STOP_LAG` more base ticks. A base-rate channel therefore counts `STOP_LAG`+1 more times, counting the tick of the write edge itself, and then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base timer tick, one cycle wide |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a pending-bit clear that lands on the same edge as a new event, because it needs a bus write timed to the exact cycle of expiry. The bench arranges it by running a channel at the undivided rate with a small interval. It counts edges from the control write to work out when the counter next holds zero, and issues the clear on the following edge. The stop lag is reached in a similar way: the bench samples the count just before the disabling write and then watches it for `STOP_LAG`+2 further cycles.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;
  // shared offsets (bytes)
  localparam int OFS_IEN    = 0;
  localparam int OFS_STS    = 4;
  localparam int CH_BASE    = 16;
  localparam int CH_STR_LG  = 5;   // 32-byte channel stride

  // control word bit positions
  localparam int CTL_EN     = 0;
  localparam int CTL_RLD    = 1;
  localparam int CTL_PRE_LO = 4;
  localparam int CTL_OS     = 7;

  typedef enum logic [2:0] {
    SEL_CTL    = 3'd0,
    SEL_IVL_LO = 3'd1,
    SEL_IVL_HI = 3'd2,
    SEL_CNT_LO = 3'd3,
    SEL_CNT_HI = 3'd4,
    SEL_NONE   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/cdtimer_decode.sv
module cdtimer_decode
  import cdtimer_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_ien,
  output logic              hit_sts,
  output logic [NCH-1:0]    ch_hit,
  output reg_sel_e          sel
);
  localparam int IDX_W = ADDR_W - CH_STR_LG;

  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;

  assign rel = addr - ADDR_W'(CH_BASE);
  assign idx = rel[ADDR_W-1:CH_STR_LG];

  always_comb begin
    hit_ien = (addr == ADDR_W'(OFS_IEN));
    hit_sts = (addr == ADDR_W'(OFS_STS));
    ch_hit  = '0;
    sel     = SEL_NONE;
    if (addr >= ADDR_W'(CH_BASE) && addr[1:0] == 2'b00 && rel[4:2] <= 3'd4) begin
      for (int i = 0; i < NCH; i++) begin
        if (idx == IDX_W'(i)) begin
          ch_hit[i] = 1'b1;
          sel       = reg_sel_e'(rel[4:2]);
        end
      end
    end
  end
endmodule

// File: rtl/cdtimer_chan.sv
module cdtimer_chan
  import cdtimer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PRE_W    = 3,
  parameter int STOP_LAG = 2,
  localparam int CNT_W   = 2 * DATA_W,
  localparam int PCNT_W  = (1 << PRE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_ctl,
  input  logic              wr_ivl_lo,
  input  logic              wr_ivl_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_rd,
  output logic [CNT_W-1:0]  ivl,
  output logic [CNT_W-1:0]  cnt,
  output logic              expire,
  output logic              en_o,
  output logic              os_o
);
  logic                en_q, rld_q, os_q;
  logic [PRE_W-1:0]    pre_q;
  logic [PCNT_W-1:0]   pcnt_q, mask;
  logic [STOP_LAG-1:0] lag_q;
  logic                ptick, active;

  assign mask   = ~({PCNT_W{1'b1}} << pre_q);
  assign ptick  = tick && ((pcnt_q & mask) == mask);
  assign active = en_q || (|lag_q);
  assign expire = ptick && !rld_q && active && (cnt == '0);
  assign en_o   = en_q;
  assign os_o   = os_q;

  always_comb begin
    ctl_rd = '0;
    ctl_rd[CTL_EN]                    = en_q;
    ctl_rd[CTL_RLD]                   = rld_q;
    ctl_rd[CTL_PRE_LO +: PRE_W]       = pre_q;
    ctl_rd[CTL_OS]                    = os_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rld_q  <= 1'b0;
      os_q   <= 1'b0;
      pre_q  <= '0;
      pcnt_q <= '0;
      lag_q  <= '0;
      ivl    <= '0;
      cnt    <= '0;
    end else begin
      if (tick) begin
        pcnt_q <= pcnt_q + 1'b1;
        lag_q  <= (lag_q << 1) | STOP_LAG'(en_q);
      end
      if (ptick) begin
        if (rld_q) begin
          cnt   <= ivl;
          rld_q <= 1'b0;
        end else if (active) begin
          if (cnt == '0) begin
            if (os_q) begin
              en_q  <= 1'b0;
              lag_q <= '0;
            end else begin
              cnt <= ivl;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
      if (wr_ivl_lo) ivl[DATA_W-1:0]     <= wdata;
      if (wr_ivl_hi) ivl[CNT_W-1:DATA_W] <= wdata;
      // a bus write to control overrides tick-driven changes
      if (wr_ctl) begin
        en_q   <= wdata[CTL_EN];
        rld_q  <= wdata[CTL_RLD];
        pre_q  <= wdata[CTL_PRE_LO +: PRE_W];
        os_q   <= wdata[CTL_OS];
        pcnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/cdtimer.sv
module cdtimer
  import cdtimer_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int PRE_W    = 3,
  parameter int STOP_LAG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic                         hit_ien, hit_sts;
  logic [NCH-1:0]               ch_hit;
  reg_sel_e                     sel;
  logic [NCH-1:0]               ien_q, sts_q, expire_v, en_v, os_v, wr_ctl_v;
  logic [NCH-1:0][DATA_W-1:0]   ctl_v;
  logic [NCH-1:0][CNT_W-1:0]    ivl_v, cnt_v;

  cdtimer_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .hit_ien(hit_ien), .hit_sts(hit_sts),
    .ch_hit(ch_hit), .sel(sel)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign wr_ctl_v[g] = bus_wr && ch_hit[g] && (sel == SEL_CTL);
    cdtimer_chan #(.DATA_W(DATA_W), .PRE_W(PRE_W), .STOP_LAG(STOP_LAG)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .wr_ctl(wr_ctl_v[g]),
      .wr_ivl_lo(bus_wr && ch_hit[g] && (sel == SEL_IVL_LO)),
      .wr_ivl_hi(bus_wr && ch_hit[g] && (sel == SEL_IVL_HI)),
      .wdata(bus_wdata),
      .ctl_rd(ctl_v[g]), .ivl(ivl_v[g]), .cnt(cnt_v[g]),
      .expire(expire_v[g]), .en_o(en_v[g]), .os_o(os_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q <= '0;
      sts_q <= '0;
    end else begin
      if (bus_wr && hit_ien) ien_q <= bus_wdata[NCH-1:0];
      // a fresh event outranks a clear in the same cycle
      sts_q <= (sts_q & ~((bus_wr && hit_sts) ? bus_wdata[NCH-1:0] : '0)) | expire_v;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ien) bus_rdata = DATA_W'(ien_q);
    if (hit_sts) bus_rdata = DATA_W'(sts_q);
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) begin
        case (sel)
          SEL_CTL:    bus_rdata = ctl_v[i];
          SEL_IVL_LO: bus_rdata = ivl_v[i][DATA_W-1:0];
          SEL_IVL_HI: bus_rdata = ivl_v[i][CNT_W-1:DATA_W];
          SEL_CNT_LO: bus_rdata = cnt_v[i][DATA_W-1:0];
          SEL_CNT_HI: bus_rdata = cnt_v[i][CNT_W-1:DATA_W];
          default:    bus_rdata = '0;
        endcase
      end
    end
  end

  assign irq = |(sts_q & ien_q);
endmodule

// File: rtl/cdtimer_chk.sv
module cdtimer_chk #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NCH-1:0]    wdata_lo,
  input logic              irq,
  input logic [NCH-1:0]    sts,
  input logic [NCH-1:0]    ien,
  input logic [NCH-1:0]    expire,
  input logic [NCH-1:0]    en_v,
  input logic [NCH-1:0]    os_v,
  input logic [NCH-1:0]    wr_ctl_v
);
  p_sts_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire) |=> ((sts & $past(expire)) == $past(expire)));

  p_sts_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & ~$past(sts) & ~$past(expire)) == '0);

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(4)) |=>
      ((sts & $past(wdata_lo) & ~$past(expire)) == '0));

  p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts == '0 || ien == '0) |-> !irq);

  for (genvar g = 0; g < NCH; g++) begin : g_os
    p_oneshot_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[g] && os_v[g] && !wr_ctl_v[g]) |=> !en_v[g]);
  end
endmodule

bind cdtimer cdtimer_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdata_lo(bus_wdata[NCH-1:0]), .irq(irq), .sts(sts_q), .ien(ien_q),
  .expire(expire_v), .en_v(en_v), .os_v(os_v), .wr_ctl_v(wr_ctl_v)
);

// File: tb/tb_cdtimer.sv
module tb_cdtimer;
  localparam int CLK_P    = 10;
  localparam int STOP_LAG = 2;
  localparam int NTBL     = 20;

  logic        clk = 1'b0;
  logic        rst_n, tick, bus_wr, irq;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cdtimer #(.NCH(4), .ADDR_W(8), .DATA_W(32), .PRE_W(3), .STOP_LAG(STOP_LAG)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {write, addr, data, expected read}; run with tick held low
  localparam logic [72:0] TBL [NTBL] = '{
    {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'h0000_000F},
    {1'b1, 8'h14, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 8'h14, 32'h0,         32'hDEAD_BEEF},
    {1'b1, 8'h78, 32'h1234_5678, 32'h0},
    {1'b0, 8'h78, 32'h0,         32'h1234_5678},
    {1'b1, 8'h1C, 32'h0000_0055, 32'h0},
    {1'b0, 8'h1C, 32'h0,         32'h0},
    {1'b1, 8'h70, 32'hFFFF_FFFE, 32'h0},
    {1'b0, 8'h70, 32'h0,         32'h0000_00F2},
    {1'b1, 8'h70, 32'h0,         32'h0},
    {1'b0, 8'h70, 32'h0,         32'h0},
    {1'b1, 8'h24, 32'h0000_AAAA, 32'h0},
    {1'b0, 8'h24, 32'h0,         32'h0},
    {1'b0, 8'h14, 32'h0,         32'hDEAD_BEEF},
    {1'b1, 8'h08, 32'h0000_0001, 32'h0},
    {1'b0, 8'h08, 32'h0,         32'h0},
    {1'b0, 8'h90, 32'h0,         32'h0},
    {1'b0, 8'h15, 32'h0,         32'h0},
    {1'b1, 8'h00, 32'h0,         32'h0}
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // called in the low phase; the write lands on the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string what);
    bus_addr = a;
    #1;
    chk(what, bus_rdata, exp);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] a_val, v;
    rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk(8'h00, 0, "R1 ien after reset");
    rd_chk(8'h04, 0, "R1 status after reset");
    rd_chk(8'h10, 0, "R1 ctl0 after reset");
    rd_chk(8'h80, 0, "R1 cnt3 hi after reset");
    chk("R1 irq after reset", irq, 0);

    // R2 R3 register map walk
    for (int i = 0; i < NTBL; i++) begin
      if (TBL[i][72]) wr(TBL[i][71:64], TBL[i][63:32]);
      else rd_chk(TBL[i][71:64], TBL[i][31:0], $sformatf("R2 R3 table row %0d", i));
    end

    // periodic channel 0, base rate
    tick = 1'b1;
    wr(8'h00, 32'h1);
    wr(8'h14, 32'd3);
    wr(8'h18, 32'd0);
    wr(8'h10, 32'h03);                       // edge P0
    @(negedge clk);                          // P1
    rd_chk(8'h1C, 3, "R4 reload copies interval");
    rd_chk(8'h10, 32'h01, "R4 reload bit self-clears");
    @(negedge clk);
    rd_chk(8'h1C, 2, "R5 decrement");
    @(negedge clk);
    rd_chk(8'h1C, 1, "R5 decrement");
    @(negedge clk);                          // P4
    rd_chk(8'h1C, 0, "R5 reaches zero");
    rd_chk(8'h04, 0, "R7 no event before zero tick");
    chk("R10 irq low before event", irq, 0);
    @(negedge clk);                          // P5
    rd_chk(8'h04, 1, "R7 status set on expiry");
    chk("R10 irq with enable", irq, 1);
    rd_chk(8'h1C, 3, "R7 periodic reload");
    wr(8'h04, 32'h1);                        // P6
    rd_chk(8'h04, 0, "R9 write one clears");
    chk("R10 irq drops", irq, 0);
    @(negedge clk);
    @(negedge clk);                          // P8, count 0
    rd_chk(8'h04, 0, "R7 period N+1");
    wr(8'h04, 32'h1);                        // P9: event and clear together
    rd_chk(8'h04, 1, "R9 event wins over clear");
    wr(8'h10, 32'h0);
    repeat (4) @(negedge clk);

    // R11 stop lag and R5 borrow, channel 2
    wr(8'h54, 32'h0);
    wr(8'h58, 32'h1);
    wr(8'h50, 32'h03);
    @(negedge clk);
    rd_chk(8'h60, 1, "R4 64-bit reload hi");
    rd_chk(8'h5C, 0, "R4 64-bit reload lo");
    @(negedge clk);
    rd_chk(8'h60, 0, "R5 borrow hi");
    rd_chk(8'h5C, 32'hFFFF_FFFF, "R5 borrow lo");
    @(negedge clk);
    rd(8'h5C, a_val);
    wr(8'h50, 32'h0);
    for (int k = 1; k <= STOP_LAG + 3; k++) begin
      if (k > 1) @(negedge clk);
      rd_chk(8'h5C, a_val - ((k < STOP_LAG + 1) ? k : STOP_LAG + 1),
             $sformatf("R11 stop lag step %0d", k));
    end

    // R6 prescale by 4, channel 3
    wr(8'h74, 32'd5);
    wr(8'h78, 32'd0);
    wr(8'h70, 32'h23);
    repeat (3) @(negedge clk);
    rd_chk(8'h7C, 0, "R6 no tick before 4 base ticks");
    @(negedge clk);
    rd_chk(8'h7C, 5, "R6 first prescaled tick");
    repeat (3) @(negedge clk);
    rd_chk(8'h7C, 5, "R6 held between prescaled ticks");
    @(negedge clk);
    rd_chk(8'h7C, 4, "R6 second prescaled tick");
    wr(8'h70, 32'h0);
    repeat (4) @(negedge clk);
    wr(8'h04, 32'hF);
    rd_chk(8'h04, 0, "R9 clear all");
    chk("R10 idle irq", irq, 0);

    // R8 one-shot channel 1 with its interrupt masked
    wr(8'h34, 32'd2);
    wr(8'h38, 32'd0);
    wr(8'h30, 32'h83);
    repeat (4) @(negedge clk);
    rd_chk(8'h04, 32'h2, "R7 status set while masked");
    chk("R10 masked irq low", irq, 0);
    rd_chk(8'h30, 32'h80, "R8 one-shot clears enable");
    repeat (3) @(negedge clk);
    rd_chk(8'h3C, 0, "R8 counter holds zero");
    rd(8'h40, v);
    chk("R8 counter hi zero", v, 0);
    wr(8'h00, 32'h3);
    chk("R10 irq after unmask", irq, 1);
    wr(8'h04, 32'h2);
    chk("R9 R10 irq after clear", irq, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule